// File: doc/BRIEF.md
# Hardware Reset and Temporary Unprotect Controller

This block watches the active-low hardware reset pin of a memory device and decides when a low level on it counts as a real reset. A low level held for at least a minimum number of clock samples becomes an effective reset. While it lasts, the block raises `core_rst`: the operation in progress is aborted, the data outputs are forced to high impedance, the configuration register goes back to its default, the read-mode state machine returns to array read, and no commands are accepted. Once the pin goes high again, `ready` returns only after a recovery time. That time is longer if an embedded program or erase was running when the reset took effect. Data reads are allowed again after a separate hold time.

The same pin can also be driven to an elevated voltage, which is reported on `pin_hv`. While that flag is set, the block enters temporary sector-unprotect mode and hands the program/erase logic an effective protection mask in which every sector is open. The exception is when write-protect is low: the two outermost boot sectors then keep whatever protection they had. The stored mask is never modified. The effective mask is formed combinationally, so dropping the flag restores the previous protection at once.

Top module: `hwr_reset_ctrl`

## Requirements
- R1: A reset takes effect (`core_rst` rises) only at the T_RP-th consecutive rising edge that samples `pin_rst_n` low. A shorter low pulse changes neither `core_rst`, `ready`, the configuration nor the read mode.
- R2: The low-time count restarts whenever the pin is sampled high. Two short pulses separated by one high sample never combine into a reset.
- R3: While `core_rst` is high, `out_en` is low, `ready` is low, and commands have no effect.
- R4: An effective reset sets `cfg_q` to CFG_DEFAULT and `rd_mode` to array read (code 0). The mode is still array read after recovery, so an interrupted operation is not resumed.
- R5: If `op_busy` was low at the edge where the reset took effect, `ready` rises T_SHORT rising edges after the first edge that samples the pin high again.
- R6: If `op_busy` was high at that edge, `ready` rises T_LONG rising edges after that first high sample.
- R7: `read_ok` rises at the later of the ready point and T_RH edges after release. `out_en` requires `read_ok`.
- R8: With `oe_n` high, `out_en` is low regardless of any other state.
- R9: With `pin_hv` high, `pin_rst_n` high and `wp_n` high, `eff_mask` is all zeros (bit i set means sector i is protected), and `unprot` is high.
- R10: With `pin_hv` high and `wp_n` low, bits 0 and NSECT-1 of `eff_mask` equal the same bits of `prot_mask`, and all other bits are zero.
- R11: With `pin_hv` low, `eff_mask` equals `prot_mask` and `unprot` is low.
- R12: A command is taken only when `cmd_valid`, `ready` and not `core_rst`. Op code 0 selects array read, 1 selects status read (mode code 1), 2 selects ident read (mode code 2), and 3 loads `cfg_q` from `cmd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Block power-on reset, active low, asynchronous |
| pin_rst_n | input | 1 | Sampled level of the device reset pin |
| pin_hv | input | 1 | Elevated voltage detected on the reset pin |
| wp_n | input | 1 | Write-protect, low keeps boot sectors protected |
| op_busy | input | 1 | Embedded program or erase is running |
| prot_mask | input | NSECT | Stored sector protection mask |
| oe_n | input | 1 | Output enable, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Command op code |
| cmd_data | input | CFG_W | Configuration value for op 3 |
| core_rst | output | 1 | Effective reset: abort, clear, return to array read |
| ready | output | 1 | Device ready for commands |
| read_ok | output | 1 | Read hold time met |
| out_en | output | 1 | Drive data outputs (low means high impedance) |
| rd_mode | output | 2 | Current read mode |
| cfg_q | output | CFG_W | Configuration register |
| eff_mask | output | NSECT | Effective protection mask for program/erase |
| unprot | output | 1 | Temporary unprotect mode active |

## Verification
The assertions assume that `pin_rst_n`, `pin_hv`, `wp_n` and `op_busy` are already synchronous to `clk` and change only between edges. They also assume that `pin_hv` is raised only while the pin reads high. The bench changes every input on the falling clock edge and sets the elevated flag only with the pin high. It holds `op_busy` steady across the edge where a reset is qualified, so the recovery choice is unambiguous.

// File: rtl/hwr_pkg.sv
package hwr_pkg;

  typedef enum logic [1:0] {
    RD_ARRAY  = 2'd0,
    RD_STATUS = 2'd1,
    RD_IDENT  = 2'd2
  } rd_mode_e;

  typedef enum logic [1:0] {
    OP_ARRAY  = 2'd0,
    OP_STATUS = 2'd1,
    OP_IDENT  = 2'd2,
    OP_CFG    = 2'd3
  } cmd_op_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/hwr_pulse_qual.sv
module hwr_pulse_qual #(
  parameter int T_RP = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic pin_rst_n,
  output logic in_rst,
  output logic take,
  output logic rel
);
  localparam int CW = $clog2(T_RP + 1);
  localparam logic [CW-1:0] LAST = CW'(T_RP - 1);

  logic [CW-1:0] lo_cnt;

  assign take = !pin_rst_n && !in_rst && (lo_cnt == LAST);
  assign rel  = in_rst && pin_rst_n;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lo_cnt <= '0;
      in_rst <= 1'b0;
    end else begin
      if (pin_rst_n)
        lo_cnt <= '0;
      else if (lo_cnt != LAST)
        lo_cnt <= lo_cnt + 1'b1;
      if (take)
        in_rst <= 1'b1;
      else if (rel)
        in_rst <= 1'b0;
    end
  end

  AST_RISE_FROM_LOW: assert property (@(posedge clk) disable iff (!por_n)
    $rose(in_rst) |-> $past(!pin_rst_n)); // R1
  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!por_n)
    $fell(in_rst) |-> $past(pin_rst_n)); // R2

endmodule

// File: rtl/hwr_recovery.sv
module hwr_recovery
  import hwr_pkg::*;
#(
  parameter int T_SHORT = 6,
  parameter int T_LONG  = 20,
  parameter int T_RH    = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic take,
  input  logic rel,
  input  logic op_busy,
  output logic ready,
  output logic read_ok
);
  localparam int TMAX = imax(imax(T_SHORT, T_LONG), T_RH);
  localparam int RW   = $clog2(TMAX + 1);
  localparam logic [RW-1:0] SHORT_END = RW'(T_SHORT - 1);
  localparam logic [RW-1:0] LONG_END  = RW'(T_LONG - 1);
  localparam logic [RW-1:0] HOLD_END  = RW'(T_RH - 1);
  localparam logic [RW-1:0] SAT       = RW'(TMAX);

  logic [RW-1:0] rc;
  logic          run, long_q, hold_q;
  logic [RW-1:0] rec_end;

  assign rec_end = long_q ? LONG_END : SHORT_END;
  assign read_ok = ready && hold_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rc     <= '0;
      run    <= 1'b0;
      long_q <= 1'b0;
      hold_q <= 1'b1;
      ready  <= 1'b1;
    end else if (take) begin
      ready  <= 1'b0;
      hold_q <= 1'b0;
      run    <= 1'b0;
      rc     <= '0;
      long_q <= op_busy;
    end else if (rel) begin
      run <= 1'b1;
      rc  <= '0;
    end else if (run) begin
      if (rc != SAT)       rc     <= rc + 1'b1;
      if (rc == rec_end)   ready  <= 1'b1;
      if (rc == HOLD_END)  hold_q <= 1'b1;
      if (ready && hold_q) run    <= 1'b0;
    end
  end

  // checker counter: edges since the last release
  logic [RW:0] since;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    since <= '0;
    else if (rel)                  since <= '0;
    else if (since != (RW+1)'(TMAX)) since <= since + 1'b1;
  end

  AST_SHORT_NOT_EARLY: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(ready) && !long_q) |-> (since >= (RW+1)'(T_SHORT))); // R5
  AST_LONG_NOT_EARLY: assert property (@(posedge clk) disable iff (!por_n)
    ($rose(ready) && long_q) |-> (since >= (RW+1)'(T_LONG))); // R6
  AST_HOLD_NOT_EARLY: assert property (@(posedge clk) disable iff (!por_n)
    $rose(read_ok) |-> (since >= (RW+1)'(T_RH))); // R7

endmodule

// File: rtl/hwr_prot_mux.sv
module hwr_prot_mux #(
  parameter int NSECT = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             unprot,
  input  logic             wp_n,
  input  logic [NSECT-1:0] prot_mask,
  output logic [NSECT-1:0] eff_mask
);
  localparam logic [NSECT-1:0] BOOT = (NSECT'(1) << (NSECT - 1)) | NSECT'(1);

  for (genvar i = 0; i < NSECT; i++) begin : g_sect
    if (i == 0 || i == NSECT - 1) begin : g_boot
      assign eff_mask[i] = prot_mask[i] && (!unprot || !wp_n);
    end else begin : g_inner
      assign eff_mask[i] = prot_mask[i] && !unprot;
    end
  end

  AST_PLAIN_MASK: assert property (@(posedge clk) disable iff (!por_n)
    !unprot |-> (eff_mask == prot_mask)); // R11
  AST_INNER_OPEN: assert property (@(posedge clk) disable iff (!por_n)
    unprot |-> ((eff_mask & ~BOOT) == '0)); // R9
  AST_BOOT_HELD: assert property (@(posedge clk) disable iff (!por_n)
    (unprot && !wp_n) |-> ((eff_mask & BOOT) == (prot_mask & BOOT))); // R10

endmodule

// File: rtl/hwr_reset_ctrl.sv
module hwr_reset_ctrl
  import hwr_pkg::*;
#(
  parameter int              NSECT       = 8,
  parameter int              CFG_W       = 4,
  parameter logic [CFG_W-1:0] CFG_DEFAULT = '0,
  parameter int              T_RP        = 4,
  parameter int              T_SHORT     = 6,
  parameter int              T_LONG      = 20,
  parameter int              T_RH        = 8
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             pin_rst_n,
  input  logic             pin_hv,
  input  logic             wp_n,
  input  logic             op_busy,
  input  logic [NSECT-1:0] prot_mask,
  input  logic             oe_n,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [CFG_W-1:0] cmd_data,
  output logic             core_rst,
  output logic             ready,
  output logic             read_ok,
  output logic             out_en,
  output logic [1:0]       rd_mode,
  output logic [CFG_W-1:0] cfg_q,
  output logic [NSECT-1:0] eff_mask,
  output logic             unprot
);
  logic     take, rel, cmd_ok;
  rd_mode_e mode_q;

  hwr_pulse_qual #(.T_RP(T_RP)) u_qual (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n),
    .in_rst(core_rst), .take(take), .rel(rel)
  );

  hwr_recovery #(.T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_RH(T_RH)) u_rec (
    .clk(clk), .por_n(por_n), .take(take), .rel(rel), .op_busy(op_busy),
    .ready(ready), .read_ok(read_ok)
  );

  assign unprot = pin_hv && pin_rst_n && !core_rst;

  hwr_prot_mux #(.NSECT(NSECT)) u_mux (
    .clk(clk), .por_n(por_n), .unprot(unprot), .wp_n(wp_n),
    .prot_mask(prot_mask), .eff_mask(eff_mask)
  );

  assign cmd_ok  = cmd_valid && ready && !core_rst;
  assign out_en  = !oe_n && !core_rst && read_ok;
  assign rd_mode = mode_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q <= RD_ARRAY;
      cfg_q  <= CFG_DEFAULT;
    end else if (core_rst) begin
      mode_q <= RD_ARRAY;
      cfg_q  <= CFG_DEFAULT;
    end else if (cmd_ok) begin
      case (cmd_op_e'(cmd_op))
        OP_ARRAY:  mode_q <= RD_ARRAY;
        OP_STATUS: mode_q <= RD_STATUS;
        OP_IDENT:  mode_q <= RD_IDENT;
        OP_CFG:    cfg_q  <= cmd_data;
        default:   mode_q <= RD_ARRAY;
      endcase
    end
  end

  AST_HIZ_IN_RST: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |-> (!out_en && !ready)); // R3
  AST_CFG_CLEARED: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> (cfg_q == CFG_DEFAULT)); // R4
  AST_MODE_ARRAY: assert property (@(posedge clk) disable iff (!por_n)
    core_rst |=> (rd_mode == 2'd0)); // R4
  AST_OE_HIZ: assert property (@(posedge clk) disable iff (!por_n)
    oe_n |-> !out_en); // R8
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    (!ready && !core_rst) |=> $stable(cfg_q)); // R12

endmodule

// File: tb/sim_hwr_reset_ctrl.sv
module sim_hwr_reset_ctrl;
  localparam int NSECT = 8, CFG_W = 4, T_RP = 4, T_SHORT = 6, T_LONG = 20, T_RH = 8;
  localparam logic [CFG_W-1:0] CDEF = 4'h0;
  localparam logic [NSECT-1:0] BOOT = 8'h81;

  logic clk = 0, por_n = 0, pin_rst_n = 1, pin_hv = 0, wp_n = 1, op_busy = 0;
  logic [NSECT-1:0] prot_mask = '0;
  logic oe_n = 0, cmd_valid = 0;
  logic [1:0] cmd_op = '0;
  logic [CFG_W-1:0] cmd_data = '0;
  logic core_rst, ready, read_ok, out_en, unprot;
  logic [1:0] rd_mode;
  logic [CFG_W-1:0] cfg_q;
  logic [NSECT-1:0] eff_mask;

  int checks = 0, fails = 0;
  logic saw_rst = 0;

  always #2 clk = ~clk;

  hwr_reset_ctrl #(.NSECT(NSECT), .CFG_W(CFG_W), .CFG_DEFAULT(CDEF), .T_RP(T_RP),
    .T_SHORT(T_SHORT), .T_LONG(T_LONG), .T_RH(T_RH)) u0 (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .pin_hv(pin_hv), .wp_n(wp_n),
    .op_busy(op_busy), .prot_mask(prot_mask), .oe_n(oe_n), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_data(cmd_data), .core_rst(core_rst), .ready(ready),
    .read_ok(read_ok), .out_en(out_en), .rd_mode(rd_mode), .cfg_q(cfg_q),
    .eff_mask(eff_mask), .unprot(unprot));

  always @(posedge clk) if (core_rst) saw_rst <= 1'b1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [CFG_W-1:0] d);
    @(negedge clk); cmd_valid = 1; cmd_op = op; cmd_data = d;
    @(negedge clk); cmd_valid = 0;
  endtask

  // low pulse of n sampled edges; then walk the recovery window
  task automatic pulse_sweep(input int n, input logic busy);
    int t, th;
    bit taken;
    taken = (n >= T_RP);
    t  = busy ? T_LONG : T_SHORT;
    th = (t > T_RH) ? t : T_RH;
    @(negedge clk); pin_rst_n = 0; op_busy = busy;
    repeat (n) @(posedge clk);
    @(negedge clk);
    check("R1 core_rst after pulse", core_rst, taken);
    check("R3 out_en during reset", out_en, !taken);
    pin_rst_n = 1; op_busy = 0;
    for (int k = 1; k <= T_LONG + 2; k++) begin
      @(posedge clk); @(negedge clk);
      check("R1 core_rst released", core_rst, 0);
      if (busy) check("R6 ready long", ready, !taken || k >= t + 1);
      else      check("R5 ready short", ready, !taken || k >= t + 1);
      check("R7 read_ok", read_ok, !taken || k >= th + 1);
      check("R7 out_en", out_en, !taken || k >= th + 1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); por_n = 1;
    @(negedge clk);
    check("R3 reset state ready", ready, 1);
    check("R7 reset state read_ok", read_ok, 1);
    check("R1 reset state core_rst", core_rst, 0);
    check("R4 reset state cfg", cfg_q, CDEF);
    check("R4 reset state mode", rd_mode, 0);
    check("R8 reset state out_en", out_en, 1);

    // R12 command decode
    send(2'd3, 4'hA); check("R12 cfg write", cfg_q, 4'hA);
    send(2'd1, 4'h0); check("R12 status mode", rd_mode, 1);
    send(2'd2, 4'h0); check("R12 ident mode", rd_mode, 2);
    send(2'd0, 4'h0); check("R12 array mode", rd_mode, 0);

    // R1 R4 R5 R6 R7 sweep of pulse length and busy state
    for (int b = 0; b < 2; b++) begin
      for (int n = 1; n <= T_RP + 1; n++) begin
        send(2'd3, CFG_W'(n + 1));
        send(2'd1, 4'h0);
        pulse_sweep(n, b[0]);
        check("R4 cfg after pulse", cfg_q, (n >= T_RP) ? CDEF : CFG_W'(n + 1));
        check("R4 mode after pulse", rd_mode, (n >= T_RP) ? 0 : 1);
      end
    end

    // R3 and R12: commands ignored while in reset and during recovery
    send(2'd3, 4'h3);
    @(negedge clk); pin_rst_n = 0;
    repeat (T_RP + 2) @(posedge clk);
    @(negedge clk); cmd_valid = 1; cmd_op = 2'd3; cmd_data = 4'h5;
    @(negedge clk); cmd_op = 2'd1;
    @(negedge clk); cmd_valid = 0;
    check("R3 core_rst held", core_rst, 1);
    check("R3 cfg ignored in reset", cfg_q, CDEF);
    check("R3 mode ignored in reset", rd_mode, 0);
    pin_rst_n = 1;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R12 ready low in recovery", ready, 0);
    send(2'd3, 4'h7);
    check("R12 cfg ignored in recovery", cfg_q, CDEF);
    repeat (T_LONG) @(posedge clk);
    @(negedge clk);
    check("R4 mode array after recovery", rd_mode, 0);
    send(2'd3, 4'h9); check("R12 cfg after ready", cfg_q, 4'h9);

    // R2 two short pulses split by one high sample
    @(negedge clk); saw_rst = 0; pin_rst_n = 0;
    repeat (T_RP - 1) @(posedge clk);
    @(negedge clk); pin_rst_n = 1;
    @(negedge clk); pin_rst_n = 0;
    repeat (T_RP - 1) @(posedge clk);
    @(negedge clk); pin_rst_n = 1;
    @(negedge clk);
    check("R2 no reset from split pulses", saw_rst, 0);
    check("R2 ready kept", ready, 1);
    check("R2 cfg kept", cfg_q, 4'h9);

    // R8 output disable
    @(negedge clk); oe_n = 1; #1 check("R8 oe_n high", out_en, 0);
    @(negedge clk); oe_n = 0; #1 check("R8 oe_n low", out_en, 1);

    // R9 R10 R11 exhaustive mask sweep
    for (int hv = 0; hv < 2; hv++)
      for (int wp = 0; wp < 2; wp++)
        for (int m = 0; m < 256; m++) begin
          @(negedge clk); pin_hv = hv[0]; wp_n = wp[0]; prot_mask = NSECT'(m);
          #1;
          if (!hv) begin
            check("R11 mask passthrough", eff_mask, m);
            check("R11 unprot low", unprot, 0);
          end else if (wp) begin
            check("R9 all open", eff_mask, 0);
            check("R9 unprot high", unprot, 1);
          end else begin
            check("R10 boot kept", eff_mask, m & BOOT);
          end
        end
    @(negedge clk); pin_hv = 0; prot_mask = 8'hC3; #1;
    check("R11 protection restored", eff_mask, 8'hC3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule